// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is the device-side read port of a read-only memory that can be read either as 16-bit words or as 8-bit bytes. A mode input picks the width. In word mode, the 21 address inputs give the word address and all sixteen data lines carry the word. In byte mode, the same 21 inputs become the upper part of a 22-bit byte address. The top data line then turns into an input that supplies the lowest byte-address bit, and only the low eight data lines are driven.

The shared top pin and the three-state outputs are modelled without a real tri-state net. The shared pin appears as a data bit with a drive enable on the output side, plus a separate address-bit input. Every data line comes with its own drive-enable bit. A build-time parameter sets the output-enable pin to active-low, active-high or ignored. A value outside those three stops elaboration. The contents come from a small in-design array whose word count is set by a parameter and computed from a fixed formula. Outputs are registered, so a read appears one clock after its inputs are presented.

Top module: `dual_rom_port`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, all sixteen drive enables are 0 and all sixteen data bits are 0.
- R2: With the mode input at 1 (word mode), chip enable active (low) and output enable active, the clock edge after the inputs are applied sets all sixteen drive enables to 1 and the data to the word at the addressed location.
- R3: In byte mode (mode input 0), the byte address is {address inputs, lowest-bit input}. A lowest bit of 0 places bits 7:0 of the addressed word on data bits 7:0, and a lowest bit of 1 places bits 15:8 there. The low eight drive enables are 1.
- R4: In byte mode, drive enables 15:8 are 0, including bit 15, which then serves as the address input.
- R5: With chip enable high (standby), all drive enables are 0 whatever the output-enable pin does, for every polarity setting.
- R6: With OE_MODE = 0, an output-enable pin at 0 allows the outputs to be driven and a pin at 1 turns all drive enables to 0.
- R7: With OE_MODE = 1, an output-enable pin at 1 allows the outputs to be driven and a pin at 0 turns all drive enables to 0.
- R8: With OE_MODE = 2, the output-enable pin has no effect: chip enable alone decides whether the outputs are driven.
- R9: Any data bit whose drive enable is 0 reads as 0.
- R10: The word at index i is {((7*i+3) mod 256) XOR 8'hC3, (13*i+41) mod 256}. The index is the low DEPTH_AW bits of the word address, so higher address bits alias onto the same locations (DEPTH_AW defaults to 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| addr | input | 21 | Word address, or upper byte-address bits in byte mode |
| addr_lsb | input | 1 | Input side of the shared top pin; lowest byte-address bit in byte mode |
| ce_n | input | 1 | Chip enable, active low |
| oe_pin | input | 1 | Output enable; polarity set by OE_MODE |
| data_out | output | 16 | Data value per line (bit 15 is the output side of the shared pin) |
| data_drive | output | 16 | Per-line drive enable; 0 means high impedance |

## Verification
The hardest situations to reach from the ports are the polarity variants. Only one OE_MODE value exists per elaborated copy, so the bench places three copies side by side on the same input wires and checks each one against the option it was built with. A second hard case is the shared top pin: it must stay undriven in byte mode even while it carries the lowest address bit. The stimulus therefore toggles that bit in byte mode and confirms that the byte lane moves while the upper drive enables stay at zero. Addresses above the array depth are also applied, to expose the aliasing of upper address bits.

// File: rtl/drp_pkg.sv
package drp_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    // Output-enable polarity options
    localparam int OE_ACT_LOW  = 0;
    localparam int OE_ACT_HIGH = 1;
    localparam int OE_IGNORED  = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] drive;
    } port_out_t;

    // Fixed content formula: one word per index
    function automatic logic [DATA_W-1:0] content_word(input int unsigned idx);
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        hi = BYTE_W'(idx * 7 + 3) ^ 8'hC3;
        lo = BYTE_W'(idx * 13 + 41);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/drp_rom_array.sv
module drp_rom_array
    import drp_pkg::*;
#(
    parameter int DEPTH_AW = 6
) (
    input  logic [DEPTH_AW-1:0] idx,
    output logic [DATA_W-1:0]   word
);
    localparam int DEPTH = 1 << DEPTH_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = content_word(i);
    end

    assign word = cells[idx];
endmodule

// File: rtl/drp_oe_decode.sv
module drp_oe_decode
    import drp_pkg::*;
#(
    parameter int OE_MODE = OE_ACT_LOW
) (
    input  logic ce_n,
    input  logic oe_pin,
    output logic read_en
);
    localparam logic IGNORE_PIN = (OE_MODE == OE_IGNORED);
    localparam logic ACT_LEVEL  = (OE_MODE == OE_ACT_HIGH);

    if (OE_MODE < OE_ACT_LOW || OE_MODE > OE_IGNORED) begin : g_bad_option
        $error("drp_oe_decode: OE_MODE must be 0, 1 or 2");
    end

    assign read_en = !ce_n && (IGNORE_PIN || (oe_pin == ACT_LEVEL));
endmodule

// File: rtl/drp_lane_select.sv
module drp_lane_select
    import drp_pkg::*;
(
    input  logic              word_mode,
    input  logic              read_en,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] word,
    output port_out_t         nxt
);
    localparam logic [DATA_W-1:0] ALL_LANES  = '1;
    localparam logic [DATA_W-1:0] BYTE_LANES = DATA_W'({BYTE_W{1'b1}});

    logic [BYTE_W-1:0] byte_val;
    logic [DATA_W-1:0] value;
    logic [DATA_W-1:0] lanes;

    always_comb begin
        byte_val = byte_hi ? word[DATA_W-1:BYTE_W] : word[BYTE_W-1:0];
        if (word_mode) begin
            value = word;
            lanes = ALL_LANES;
        end else begin
            value = DATA_W'(byte_val);
            lanes = BYTE_LANES;
        end
        nxt.drive = read_en ? lanes : '0;
        nxt.data  = value & nxt.drive;
    end
endmodule

// File: rtl/dual_rom_port.sv
module dual_rom_port
    import drp_pkg::*;
#(
    parameter int DEPTH_AW = 6,
    parameter int OE_MODE  = OE_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic              ce_n,
    input  logic              oe_pin,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] data_drive
);
    logic [DATA_W-1:0] word;
    logic              read_en;
    logic              unused_addr_bits;
    port_out_t         nxt;
    port_out_t         q;

    assign unused_addr_bits = ^addr[ADDR_W-1:DEPTH_AW];

    drp_rom_array #(.DEPTH_AW(DEPTH_AW)) u_array (
        .idx  (addr[DEPTH_AW-1:0]),
        .word (word)
    );

    drp_oe_decode #(.OE_MODE(OE_MODE)) u_oe (
        .ce_n    (ce_n),
        .oe_pin  (oe_pin),
        .read_en (read_en)
    );

    drp_lane_select u_lanes (
        .word_mode (word_mode),
        .read_en   (read_en),
        .byte_hi   (addr_lsb),
        .word      (word),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign data_out   = q.data;
    assign data_drive = q.drive;

    // R5: standby releases every line
    assert_standby_release_R5: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (data_drive == '0));

    // R4: byte mode never drives the upper lanes, shared pin included
    assert_byte_upper_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !word_mode |=> (data_drive[DATA_W-1:BYTE_W] == '0));

    // R2: enabled word read drives all lanes
    assert_word_full_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (read_en && word_mode) |=> (data_drive == '1));

    // R3: enabled byte read drives the low lanes
    assert_byte_low_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (read_en && !word_mode) |=> (data_drive[BYTE_W-1:0] == '1));

    // R9: undriven lines read zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ((data_out & ~data_drive) == '0));
endmodule

// File: tb/sim_dual_rom_port.sv
module sim_dual_rom_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_mode = 1'b1;
    logic [20:0] addr = '0;
    logic        addr_lsb = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_pin = 1'b1;

    logic [15:0] dout0, drv0, dout1, drv1, dout2, drv2;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_rom_port #(.OE_MODE(0)) u0 (.clk(clk), .rst(rst), .word_mode(word_mode), .addr(addr),
        .addr_lsb(addr_lsb), .ce_n(ce_n), .oe_pin(oe_pin), .data_out(dout0), .data_drive(drv0));
    dual_rom_port #(.OE_MODE(1)) u1 (.clk(clk), .rst(rst), .word_mode(word_mode), .addr(addr),
        .addr_lsb(addr_lsb), .ce_n(ce_n), .oe_pin(oe_pin), .data_out(dout1), .data_drive(drv1));
    dual_rom_port #(.OE_MODE(2)) u2 (.clk(clk), .rst(rst), .word_mode(word_mode), .addr(addr),
        .addr_lsb(addr_lsb), .ce_n(ce_n), .oe_pin(oe_pin), .data_out(dout2), .data_drive(drv2));

    // R10 content formula, from the requirement
    function automatic logic [15:0] exp_word(input logic [20:0] a);
        int unsigned i;
        logic [7:0] hi, lo;
        i  = int'(a[5:0]);
        hi = 8'(i * 7 + 3) ^ 8'hC3;
        lo = 8'(i * 13 + 41);
        return {hi, lo};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs at falling edge, sample after the next rising edge
    task automatic apply(input logic wm, input logic [20:0] a, input logic lsb,
                         input logic ce, input logic oe);
        @(negedge clk);
        word_mode = wm; addr = a; addr_lsb = lsb; ce_n = ce; oe_pin = oe;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R1 drive u0", drv0, 16'h0000);
        check("R1 data u0", dout0, 16'h0000);
        check("R1 drive u2", drv2, 16'h0000);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_word();
        logic [20:0] list [5] = '{21'd0, 21'd5, 21'd63, 21'd64, 21'h1FFFFF};
        foreach (list[k]) begin
            apply(1'b1, list[k], 1'b0, 1'b0, 1'b0);
            check("R2 word data", dout0, exp_word(list[k]));
            check("R2 word drive", drv0, 16'hFFFF);
        end
        check("R10 alias top address", dout0, exp_word(21'd63));
    endtask

    task automatic t_byte();
        logic [15:0] w;
        w = exp_word(21'd9);
        apply(1'b0, 21'd9, 1'b0, 1'b0, 1'b0);
        check("R3 low byte", dout0, {8'h00, w[7:0]});
        check("R4 byte drive", drv0, 16'h00FF);
        apply(1'b0, 21'd9, 1'b1, 1'b0, 1'b0);
        check("R3 high byte", dout0, {8'h00, w[15:8]});
        check("R4 byte drive lsb1", drv0, 16'h00FF);
        apply(1'b0, 21'd70, 1'b1, 1'b0, 1'b0);
        w = exp_word(21'd70);
        check("R3 high byte aliased", dout0, {8'h00, w[15:8]});
    endtask

    task automatic t_standby();
        for (int o = 0; o < 2; o++) begin
            apply(1'b1, 21'd12, 1'b0, 1'b1, o[0]);
            check("R5 standby u0", drv0, 16'h0000);
            check("R5 standby u1", drv1, 16'h0000);
            check("R5 standby u2", drv2, 16'h0000);
            check("R9 standby data", dout2, 16'h0000);
        end
    endtask

    task automatic t_polarity();
        apply(1'b1, 21'd33, 1'b0, 1'b0, 1'b0);
        check("R6 low enables", drv0, 16'hFFFF);
        check("R7 low disables", drv1, 16'h0000);
        check("R9 disabled data", dout1, 16'h0000);
        check("R8 ignored pin 0", drv2, 16'hFFFF);
        check("R8 ignored data", dout2, exp_word(21'd33));
        apply(1'b1, 21'd33, 1'b0, 1'b0, 1'b1);
        check("R6 high disables", drv0, 16'h0000);
        check("R9 disabled data u0", dout0, 16'h0000);
        check("R7 high enables", drv1, 16'hFFFF);
        check("R7 data", dout1, exp_word(21'd33));
        check("R8 ignored pin 1", drv2, 16'hFFFF);
    endtask

    initial begin
        t_reset();
        t_word();
        t_byte();
        t_standby();
        t_polarity();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule